// File: doc/BRIEF.md
# Synchronous Host Bus RAM Slave

This block sits in programmable fabric and answers a processor's external memory controller that has been set up for synchronous, single-word, non-multiplexed 16-bit accesses. Every strobe is sampled on the bus clock supplied by the host. An active-low select qualifies the cycle. A low write strobe stores the word on the shared data pins into an internal two-port RAM. A low output strobe makes the slave drive the RAM word onto those same pins. At all other times the pins are left at high impedance.

The RAM's second port runs on its own clock and has its own address, write enable and data lines. Fabric logic, such as a converter sample buffer, can fill the RAM for the host to read, or drain words that the host wrote. The two ports never need to agree on timing. The storage is built from two banks, so that each bank has exactly one writer.

Top module: `hostbus_ram_slave`

## Requirements
- R1: The slave leaves `hb_data` undriven (high impedance) whenever `hb_cs_n` is high or `hb_oe_n` is high, including during reset.
- R2: On a bus clock rising edge with `hb_cs_n` and `hb_we_n` both low, the word on `hb_data` is stored at word address `hb_addr` (256 locations with the default 8-bit address).
- R3: On a bus clock rising edge with `hb_cs_n` low and `hb_we_n` high, the word at `hb_addr` is captured. It appears on `hb_data` after that edge, while `hb_cs_n` and `hb_oe_n` are low and `hb_we_n` is high. This gives one bus clock of read latency. The captured word holds while the slave is deselected or writing.
- R4: When `hb_cs_n`, `hb_oe_n` and `hb_we_n` are all low, the write takes priority: the word is stored and the slave does not drive `hb_data`.
- R5: While `hb_cs_n` is high, a low `hb_we_n` stores nothing.
- R6: A word written through the fabric port (`fab_we` high at a `fab_clk` rising edge) is returned by a later host read of the same address.
- R7: A word written by the host is returned on `fab_rdata` one `fab_clk` edge after `fab_addr` is sampled.
- R8: When the fabric port writes an address at a `fab_clk` edge, `fab_rdata` from that edge shows the word held before the write.
- R9: Host and fabric writes that overlap in time both land when their addresses differ. Overlapping writes to one address disturb no other location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock driven by the host controller |
| bus_rst_n | input | 1 | Active-low synchronous reset, bus clock domain |
| hb_addr | input | ADDR_W | Host word address |
| hb_cs_n | input | 1 | Active-low chip select |
| hb_oe_n | input | 1 | Active-low output enable (read strobe) |
| hb_we_n | input | 1 | Active-low write enable |
| hb_data | inout | DATA_W | Shared bidirectional data pins |
| fab_clk | input | 1 | Fabric-side RAM clock |
| fab_addr | input | ADDR_W | Fabric-side word address |
| fab_we | input | 1 | Fabric-side write enable, active high |
| fab_wdata | input | DATA_W | Fabric-side write word |
| fab_rdata | output | DATA_W | Fabric-side registered read word |

## Verification
The host side is driven with single writes and reads to the end addresses 0 and 255 and to interior addresses. It also runs a write followed directly by a read of the same address, and back-to-back reads of different addresses. These show whether the address is decoded at all, and whether read data lags its address by exactly one clock. Strobe combinations with one signal off pattern are checked against the pulled-up idle level, and against a word that is read back afterwards. This separates the read path, the write-priority case and the deselected case. Cross-port transfers run in both directions, together with a fabric read-during-write, overlapping writes to different addresses, and an overlapping write to one address. These show whether the two banks merge correctly and whether a collision stays confined to its own word.

// File: rtl/hbram_pkg.sv
`timescale 1ns/1ps
package hbram_pkg;
   // decoded state of the host strobes in one bus clock
   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_ADDR  = 2'd1,   // selected, not writing: capture read word
      HB_WRITE = 2'd2    // selected, writing
   } hb_op_e;
endpackage

// File: rtl/hbram_strobe_dec.sv
`timescale 1ns/1ps
module hbram_strobe_dec
   import hbram_pkg::*;
(
   input  logic   cs_n,
   input  logic   oe_n,
   input  logic   we_n,
   output hb_op_e op,
   output logic   drive_en
);
   always_comb begin
      if (cs_n)      op = HB_IDLE;
      else if (!we_n) op = HB_WRITE;
      else            op = HB_ADDR;
   end

   // pins are driven only for a selected read; a write always wins
   always_comb drive_en = (op == HB_ADDR) && !oe_n;
endmodule

// File: rtl/hbram_bus_io.sv
`timescale 1ns/1ps
module hbram_bus_io #(
   parameter int DATA_W = 16
) (
   input  logic              drive_en,
   input  logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] pad,
   output logic [DATA_W-1:0] din
);
   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_lane
         assign pad[b] = drive_en ? rdata[b] : 1'bz;
      end
   endgenerate

   assign din = pad;
endmodule

// File: rtl/hbram_xor_dpram.sv
`timescale 1ns/1ps
module hbram_xor_dpram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              a_clk,
   input  logic              a_rst_n,
   input  logic              a_sel,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_clk,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   // word = bank_a ^ bank_b; each bank has a single writing clock
   logic [DATA_W-1:0] bank_a [DEPTH];
   logic [DATA_W-1:0] bank_b [DEPTH];

   logic [DATA_W-1:0] a_word;
   logic [DATA_W-1:0] b_word;

   assign a_word = bank_a[a_addr] ^ bank_b[a_addr];
   assign b_word = bank_a[b_addr] ^ bank_b[b_addr];

   always_ff @(posedge a_clk) begin
      if (a_we) bank_a[a_addr] <= a_wdata ^ bank_b[a_addr];
   end

   always_ff @(posedge a_clk) begin
      if (!a_rst_n)   a_rdata <= '0;
      else if (a_sel) a_rdata <= a_word;
   end

   always_ff @(posedge b_clk) begin
      if (b_we) bank_b[b_addr] <= b_wdata ^ bank_a[b_addr];
      b_rdata <= b_word;   // old word on read-during-write
   end
endmodule

// File: rtl/hostbus_ram_slave.sv
`timescale 1ns/1ps
module hostbus_ram_slave
   import hbram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic [ADDR_W-1:0] hb_addr,
   input  logic              hb_cs_n,
   input  logic              hb_oe_n,
   input  logic              hb_we_n,
   inout  wire  [DATA_W-1:0] hb_data,
   input  logic              fab_clk,
   input  logic [ADDR_W-1:0] fab_addr,
   input  logic              fab_we,
   input  logic [DATA_W-1:0] fab_wdata,
   output logic [DATA_W-1:0] fab_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("hostbus_ram_slave: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("hostbus_ram_slave: DATA_W must lie in 1..64");
      end
   endgenerate

   hb_op_e            host_op;
   logic              drive_en;
   logic [DATA_W-1:0] host_din;
   logic [DATA_W-1:0] host_rdata;
   logic              host_sel;
   logic              host_we;

   assign host_sel = (host_op == HB_ADDR);
   assign host_we  = (host_op == HB_WRITE);

   hbram_strobe_dec u_dec (
      .cs_n     (hb_cs_n),
      .oe_n     (hb_oe_n),
      .we_n     (hb_we_n),
      .op       (host_op),
      .drive_en (drive_en)
   );

   hbram_bus_io #(.DATA_W(DATA_W)) u_io (
      .drive_en (drive_en),
      .rdata    (host_rdata),
      .pad      (hb_data),
      .din      (host_din)
   );

   hbram_xor_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .a_clk   (bus_clk),
      .a_rst_n (bus_rst_n),
      .a_sel   (host_sel),
      .a_we    (host_we),
      .a_addr  (hb_addr),
      .a_wdata (host_din),
      .a_rdata (host_rdata),
      .b_clk   (fab_clk),
      .b_we    (fab_we),
      .b_addr  (fab_addr),
      .b_wdata (fab_wdata),
      .b_rdata (fab_rdata)
   );
endmodule

// File: rtl/hbram_checker.sv
`timescale 1ns/1ps
module hbram_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              hb_cs_n,
   input logic              hb_oe_n,
   input logic              hb_we_n,
   input logic [ADDR_W-1:0] hb_addr,
   input logic [DATA_W-1:0] host_din,
   input logic [DATA_W-1:0] host_rdata,
   input logic              drive_en
);
   // R1: no drive unless selected with the output strobe low
   p_hiz_idle_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (hb_cs_n || hb_oe_n) |-> !drive_en);

   // R4: a selected write never drives the pins
   p_write_wins_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!hb_cs_n && !hb_we_n) |-> !drive_en);

   // R3: captured read word holds while deselected or writing
   p_rd_hold_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (hb_cs_n || !hb_we_n) |=> $stable(host_rdata));

   // R2: a write followed at once by a read of that address returns the word
   p_write_read_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      ($past(!hb_cs_n && !hb_we_n) && !hb_cs_n && hb_we_n && (hb_addr == $past(hb_addr)))
      |=> (host_rdata == $past(host_din, 2)));
endmodule

bind hostbus_ram_slave hbram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .bus_clk    (bus_clk),
   .bus_rst_n  (bus_rst_n),
   .hb_cs_n    (hb_cs_n),
   .hb_oe_n    (hb_oe_n),
   .hb_we_n    (hb_we_n),
   .hb_addr    (hb_addr),
   .host_din   (host_din),
   .host_rdata (host_rdata),
   .drive_en   (drive_en)
);

// File: tb/test_hostbus_ram_slave.sv
`timescale 1ns/1ps
module test_hostbus_ram_slave;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam logic [DW-1:0] PULLED = 16'hFFFF;

   logic          bus_clk = 1'b0;
   logic          fab_clk = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic [AW-1:0] hb_addr = '0;
   logic          hb_cs_n = 1'b1;
   logic          hb_oe_n = 1'b1;
   logic          hb_we_n = 1'b1;
   tri1  [DW-1:0] hb_data;
   logic          tb_drv = 1'b0;
   logic [DW-1:0] tb_val = '0;
   logic [AW-1:0] fab_addr = '0;
   logic          fab_we = 1'b0;
   logic [DW-1:0] fab_wdata = '0;
   logic [DW-1:0] fab_rdata;

   assign hb_data = tb_drv ? tb_val : {DW{1'bz}};

   always #4 bus_clk = ~bus_clk;   // 125 MHz
   always #5 fab_clk = ~fab_clk;

   hostbus_ram_slave #(.ADDR_W(AW), .DATA_W(DW)) i_hostbus_ram_slave (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .hb_addr(hb_addr),
      .hb_cs_n(hb_cs_n), .hb_oe_n(hb_oe_n), .hb_we_n(hb_we_n), .hb_data(hb_data),
      .fab_clk(fab_clk), .fab_addr(fab_addr), .fab_we(fab_we),
      .fab_wdata(fab_wdata), .fab_rdata(fab_rdata)
   );

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   sb_item_t cur;
   int  n_vec = 0;
   int  n_bad = 0;
   logic pend = 1'b0;
   bit  done = 1'b0;

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // monitor: compares the pins shortly after each bus edge that has a pending item
   always @(posedge bus_clk) begin
      #2;
      if (pend) begin
         if (sb_q.size() == 0) begin
            check("scoreboard underflow", '0, '1);
         end else begin
            cur = sb_q.pop_front();
            check(cur.tag, hb_data, cur.exp);
         end
      end
   end

   // ---------------- host driver tasks (drive at falling edge) ----------------
   task automatic host_idle();
      @(negedge bus_clk);
      pend = 1'b0; hb_cs_n = 1'b1; hb_oe_n = 1'b1; hb_we_n = 1'b1; tb_drv = 1'b0;
   endtask

   task automatic host_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge bus_clk);
      pend = 1'b0; hb_addr = a; hb_cs_n = 1'b0; hb_oe_n = 1'b1; hb_we_n = 1'b0;
      tb_val = d; tb_drv = 1'b1;
   endtask

   task automatic host_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
      @(negedge bus_clk);
      hb_addr = a; hb_cs_n = 1'b0; hb_oe_n = 1'b0; hb_we_n = 1'b1; tb_drv = 1'b0;
      sb_q.push_back('{exp: exp, tag: tag});
      pend = 1'b1;
   endtask

   // arbitrary strobe pattern, tb optionally driving, with expected pin value
   task automatic host_probe(logic cs, logic oe, logic we, logic [AW-1:0] a,
                             logic drv, logic [DW-1:0] d, logic [DW-1:0] exp, string tag);
      @(negedge bus_clk);
      hb_addr = a; hb_cs_n = cs; hb_oe_n = oe; hb_we_n = we; tb_val = d; tb_drv = drv;
      sb_q.push_back('{exp: exp, tag: tag});
      pend = 1'b1;
   endtask

   // ---------------- fabric tasks ----------------
   task automatic fab_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge fab_clk);
      fab_addr = a; fab_we = 1'b1; fab_wdata = d;
      @(negedge fab_clk);
      fab_we = 1'b0;
   endtask

   task automatic fab_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
      @(negedge fab_clk);
      fab_addr = a; fab_we = 1'b0;
      @(negedge fab_clk);
      check(tag, fab_rdata, exp);
   endtask

   task automatic fab_rdw(logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] old, string tag);
      @(negedge fab_clk);
      fab_addr = a; fab_we = 1'b1; fab_wdata = d;
      @(negedge fab_clk);
      fab_we = 1'b0;
      check(tag, fab_rdata, old);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: pins undriven during reset
      repeat (3) @(negedge bus_clk);
      check("R1 reset", hb_data, PULLED);
      bus_rst_n = 1'b1;
      host_idle();

      // R2: writes at both end addresses and interior ones, back to back
      host_write(8'd0,   16'hA5A5);
      host_write(8'd255, 16'h5A5A);
      host_write(8'd1,   16'h0001);
      host_write(8'd2,   16'h8000);
      host_write(8'd17,  16'h1234);
      host_read (8'd17,  16'h1234, "R2 write then read");
      host_read (8'd0,   16'hA5A5, "R2 addr 0");
      host_read (8'd255, 16'h5A5A, "R2 addr 255");
      // R3: consecutive reads of different addresses, one clock of latency each
      host_read (8'd1,   16'h0001, "R3 read 1");
      host_read (8'd2,   16'h8000, "R3 read 2");
      host_read (8'd1,   16'h0001, "R3 read 1 again");
      host_idle();

      // R1: selected without output strobe, and output strobe without select
      host_probe(1'b0, 1'b1, 1'b1, 8'd2, 1'b0, '0, PULLED, "R1 oe high");
      host_probe(1'b1, 1'b0, 1'b1, 8'd2, 1'b0, '0, PULLED, "R1 cs high");
      host_idle();

      // R4: all strobes low: pins carry host word, and it is stored
      host_probe(1'b0, 1'b0, 1'b0, 8'd3, 1'b1, 16'h0F0F, 16'h0F0F, "R4 no drive");
      host_read (8'd3, 16'h0F0F, "R4 stored");
      host_idle();

      // R5: write strobe while deselected stores nothing
      host_probe(1'b1, 1'b1, 1'b0, 8'd1, 1'b1, 16'hDEAD, 16'hDEAD, "R5 pins");
      host_idle();
      host_read (8'd1, 16'h0001, "R5 unchanged");
      host_idle();

      // R6: fabric writes, host reads
      fab_write(8'd40, 16'hC3C3);
      fab_write(8'd41, 16'h3C3C);
      host_read(8'd40, 16'hC3C3, "R6 addr 40");
      host_read(8'd41, 16'h3C3C, "R6 addr 41");
      host_idle();

      // R7: host words seen by the fabric port
      fab_read(8'd255, 16'h5A5A, "R7 addr 255");
      fab_read(8'd17,  16'h1234, "R7 addr 17");
      fab_read(8'd3,   16'h0F0F, "R7 addr 3");

      // R8: fabric read-during-write returns the old word
      fab_rdw (8'd40, 16'h7777, 16'hC3C3, "R8 old word");
      fab_read(8'd40, 16'h7777, "R8 new word");
      host_read(8'd40, 16'h7777, "R8 host view");
      host_idle();

      // R9: overlapping writes
      host_write(8'd100, 16'h1111);
      host_write(8'd101, 16'h2222);
      host_write(8'd102, 16'h3333);
      host_idle();
      fork
         host_write(8'd100, 16'hAAAA);
         fab_write (8'd102, 16'hBBBB);
      join
      host_idle();
      host_read(8'd100, 16'hAAAA, "R9 host side");
      host_read(8'd102, 16'hBBBB, "R9 fabric side");
      host_idle();
      fork
         host_write(8'd101, 16'hCCCC);
         fab_write (8'd101, 16'hDDDD);
      join
      host_idle();
      host_read(8'd100, 16'hAAAA, "R9 neighbour below");
      host_read(8'd102, 16'hBBBB, "R9 neighbour above");
      host_read(8'd0,   16'hA5A5, "R9 far word");
      host_idle();

      repeat (4) @(negedge bus_clk);
      if (sb_q.size() != 0) check("scoreboard leftover", 16'(sb_q.size()), '0);
      finish_run();
   end
endmodule